// File: doc/BRIEF.md
# Sampling ADC Parallel-Bus Sequencer

This block runs an 8-bit successive-approximation converter that sits on a parallel data bus. One start request from the user side sets off a full cycle. The block raises or lowers the convert-start line, waits for the converter's busy flag to go high and then low again, and reads the result with a chip-select plus read-strobe cycle. It then presents the byte together with a one-clock valid pulse. Every timing interval is a count of system-clock cycles set by a parameter.

The level of convert-start when a conversion ends decides whether the converter stays powered. The block therefore shapes that line in one of two ways, chosen per request:

- **Power-saving mode.** The block raises convert-start, holds it through a power-up wait, and then lowers it. The line stays low until the result is read, so the converter goes back to sleep.
- **High-throughput mode.** The block gives only a short low pulse, so the line is high again before busy falls and the converter stays powered. A later high-throughput request then needs no wake phase.

Busy is brought into the clock domain through a synchroniser. If busy does not complete within a time limit, the block reports an error pulse instead of a result.

Top module: `adc_host_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, convert-start is low, chip-select and read are high (inactive), valid is low and error is low.
- R2: In power-saving mode (mode input 1), convert-start is high for exactly PWRUP_CYC cycles, beginning in the cycle after the start request is sampled. It then goes low and stays low until busy has fallen. A converter that was asleep never sees a falling edge earlier than the power-up time after the rising edge.
- R3: In high-throughput mode (mode input 0), when convert-start is already high in idle, the line falls in the cycle after the start request is sampled. It stays low for exactly PULSE_CYC cycles and is high again when busy falls.
- R4: A high-throughput request made while convert-start is low goes through the same PWRUP_CYC-cycle high phase as R2 before its falling edge.
- R5: Read and chip-select go low together in the cycle that comes SYNC_STAGES+1 cycles after busy falls at the pin. They stay low for exactly RD_CYC cycles.
- R6: The result is taken from the data bus in the last cycle in which read is low. Valid is high for exactly one cycle, in the first cycle after read returns high, and the data output carries that byte.
- R7: After read returns high, convert-start does not fall for at least GAP_CYC cycles. A start request held high from that moment produces the fall GAP_CYC+1 cycles after read rises.
- R8: A start request made while a cycle is in progress is ignored, and so is a mode change at that time. Only one convert-start fall and one valid pulse result, with the mode that was sampled at the accepted start.
- R9: If busy has not completed within TIMEOUT_CYC cycles of the convert-start fall, error pulses high for one cycle, exactly TIMEOUT_CYC cycles after the fall. No read cycle and no valid pulse follow, and the next request is served normally.
- R10: The data output changes only together with a valid pulse and otherwise holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled in idle |
| pdown_i | input | 1 | Mode for the request: 1 power-saving, 0 high-throughput |
| adc_busy_i | input | 1 | Converter busy flag (asynchronous) |
| adc_db_i | input | DATA_W | Converter data bus |
| adc_convst_o | output | 1 | Convert-start line |
| adc_cs_n_o | output | 1 | Chip select, active low |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| data_o | output | DATA_W | Last conversion result |
| valid_o | output | 1 | One-cycle pulse when data_o is new |
| err_o | output | 1 | One-cycle pulse on busy timeout |

## Verification
The convert-start edges follow the accepted start by a fixed count: one cycle to the rise or fall, and PWRUP_CYC or PULSE_CYC cycles to the opposite edge. The read strobe begins SYNC_STAGES+1 cycles after busy falls, and valid comes RD_CYC cycles after that. The timeout error comes TIMEOUT_CYC cycles after the convert-start fall. The bench samples on the falling clock edge and numbers each one from the start request. It records the index at which each port changes and compares the difference between indices with these counts, so a change in any register stage shows up as an exact mismatch. A cycle-level converter model in the bench produces busy and the data bus and reports any falling edge that comes too early after a wake.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_WAKE,
        SEQ_CONV,
        SEQ_READ,
        SEQ_GAP
    } seq_state_t;

    typedef struct packed {
        logic convst;
        logic cs_n;
        logic rd_n;
    } adc_pins_t;

    localparam adc_pins_t PINS_QUIET = '{convst: 1'b0, cs_n: 1'b1, rd_n: 1'b1};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // bits needed to count 0 .. lim-1
    function automatic int unsigned cnt_bits(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim);
    endfunction

endpackage

// File: rtl/adc_hc_sync.sv
module adc_hc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_hc_seq.sv
module adc_hc_seq
    import adc_host_pkg::*;
#(
    parameter int PWRUP_CYC   = 125,
    parameter int PULSE_CYC   = 4,
    parameter int RD_CYC      = 2,
    parameter int GAP_CYC     = 13,
    parameter int TIMEOUT_CYC = 600
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      pdown_i,
    input  logic      busy_s_i,
    output adc_pins_t pins_o,
    output logic      capture_o,
    output logic      timeout_o
);
    localparam int unsigned CNT_LIM =
        max2(max2(PWRUP_CYC, TIMEOUT_CYC), max2(max2(RD_CYC, GAP_CYC), PULSE_CYC));
    localparam int unsigned CW = cnt_bits(CNT_LIM);
    localparam logic [CW-1:0] PWRUP_LAST = CW'(PWRUP_CYC - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] RD_LAST    = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_CYC - 1);
    localparam logic [CW-1:0] TO_LAST    = CW'(TIMEOUT_CYC - 1);

    seq_state_t    state_q;
    logic [CW-1:0] cnt_q;
    logic          convst_q;
    logic          pd_q;
    logic          seen_q;
    logic          err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            cnt_q    <= '0;
            convst_q <= 1'b0;
            pd_q     <= 1'b0;
            seen_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        pd_q   <= pdown_i;
                        cnt_q  <= '0;
                        seen_q <= 1'b0;
                        if (pdown_i || !convst_q) begin
                            state_q  <= SEQ_WAKE;
                            convst_q <= 1'b1;
                        end else begin
                            state_q  <= SEQ_CONV;
                            convst_q <= 1'b0;
                        end
                    end
                end
                SEQ_WAKE: begin
                    if (cnt_q == PWRUP_LAST) begin
                        state_q  <= SEQ_CONV;
                        convst_q <= 1'b0;
                        cnt_q    <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_CONV: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (!pd_q && cnt_q == PULSE_LAST) convst_q <= 1'b1;
                    if (busy_s_i) seen_q <= 1'b1;
                    if (seen_q && !busy_s_i) begin
                        state_q <= SEQ_READ;
                        cnt_q   <= '0;
                    end else if (cnt_q == TO_LAST) begin
                        state_q <= SEQ_GAP;
                        cnt_q   <= '0;
                        err_q   <= 1'b1;
                    end
                end
                SEQ_READ: begin
                    if (cnt_q == RD_LAST) begin
                        state_q <= SEQ_GAP;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_GAP: begin
                    if (cnt_q == GAP_LAST) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    logic reading;
    assign reading = (state_q == SEQ_READ);

    always_comb begin
        pins_o        = PINS_QUIET;
        pins_o.convst = convst_q;
        pins_o.cs_n   = !reading;
        pins_o.rd_n   = !reading;
    end

    assign capture_o = reading && (cnt_q == RD_LAST);
    assign timeout_o = err_q;
endmodule

// File: rtl/adc_hc_capture.sv
module adc_hc_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] db_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= strobe_i;
            if (strobe_i) data_o <= db_i;
        end
    end
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PWRUP_CYC   = 125,
    parameter int PULSE_CYC   = 4,
    parameter int RD_CYC      = 2,
    parameter int GAP_CYC     = 13,
    parameter int TIMEOUT_CYC = 600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              pdown_i,
    input  logic              adc_busy_i,
    input  logic [DATA_W-1:0] adc_db_i,
    output logic              adc_convst_o,
    output logic              adc_cs_n_o,
    output logic              adc_rd_n_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);
    logic      busy_s;
    logic      capture;
    adc_pins_t pins;

    adc_hc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (adc_busy_i),
        .q_o (busy_s)
    );

    adc_hc_seq #(
        .PWRUP_CYC   (PWRUP_CYC),
        .PULSE_CYC   (PULSE_CYC),
        .RD_CYC      (RD_CYC),
        .GAP_CYC     (GAP_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .pdown_i   (pdown_i),
        .busy_s_i  (busy_s),
        .pins_o    (pins),
        .capture_o (capture),
        .timeout_o (err_o)
    );

    adc_hc_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (capture),
        .db_i     (adc_db_i),
        .data_o   (data_o),
        .valid_o  (valid_o)
    );

    assign adc_convst_o = pins.convst;
    assign adc_cs_n_o   = pins.cs_n;
    assign adc_rd_n_o   = pins.rd_n;
endmodule

// File: rtl/adc_host_ctrl_chk.sv
module adc_host_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_convst_o,
    input logic              adc_cs_n_o,
    input logic              adc_rd_n_o,
    input logic [DATA_W-1:0] data_o,
    input logic              valid_o,
    input logic              err_o
);
    assert_rd_inside_cs_R5: assert property (@(posedge clk) disable iff (rst)
        !adc_rd_n_o |-> !adc_cs_n_o);

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_valid_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($past(adc_rd_n_o) == 1'b0) && adc_rd_n_o);

    assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_o) |-> valid_o);

    assert_err_single_R9: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);

    assert_err_no_result_R9: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !valid_o && adc_rd_n_o);

    assert_no_fall_while_reading_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_convst_o) |-> adc_cs_n_o && adc_rd_n_o);
endmodule

bind adc_host_ctrl adc_host_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .adc_convst_o (adc_convst_o),
    .adc_cs_n_o   (adc_cs_n_o),
    .adc_rd_n_o   (adc_rd_n_o),
    .data_o       (data_o),
    .valid_o      (valid_o),
    .err_o        (err_o)
);

// File: tb/tb_adc_host_ctrl.sv
module tb_adc_host_ctrl;
    localparam int DW    = 8;
    localparam int SYNC  = 2;
    localparam int PWRUP = 12;
    localparam int PULSE = 4;
    localparam int RDC   = 2;
    localparam int GAP   = 13;
    localparam int TMO   = 80;

    // {mode, sample, conversion length}
    localparam logic [16:0] VEC [0:5] = '{
        {1'b0, 8'hA5, 8'd20},
        {1'b0, 8'h3C, 8'd9},
        {1'b1, 8'hFF, 8'd30},
        {1'b1, 8'h00, 8'd15},
        {1'b0, 8'h81, 8'd40},
        {1'b0, 8'h5A, 8'd12}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          pdown_i = 1'b0;
    logic          adc_busy_i;
    logic [DW-1:0] adc_db_i;
    logic          adc_convst_o, adc_cs_n_o, adc_rd_n_o, valid_o, err_o;
    logic [DW-1:0] data_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    adc_host_ctrl #(
        .DATA_W(DW), .SYNC_STAGES(SYNC), .PWRUP_CYC(PWRUP), .PULSE_CYC(PULSE),
        .RD_CYC(RDC), .GAP_CYC(GAP), .TIMEOUT_CYC(TMO)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .pdown_i(pdown_i),
        .adc_busy_i(adc_busy_i), .adc_db_i(adc_db_i),
        .adc_convst_o(adc_convst_o), .adc_cs_n_o(adc_cs_n_o), .adc_rd_n_o(adc_rd_n_o),
        .data_o(data_o), .valid_o(valid_o), .err_o(err_o)
    );

    // converter model
    logic          m_busy = 1'b0;
    logic          m_asleep = 1'b1;
    logic          m_noresp = 1'b0;
    logic          cv_d = 1'b0;
    logic [DW-1:0] m_sample = '0;
    int            m_len = 10;
    int            m_rem = 0;
    int            rise_age = 1000;
    int            wake_viol = 0;

    assign adc_busy_i = m_busy;
    assign adc_db_i   = (!adc_cs_n_o && !adc_rd_n_o) ? m_sample : 8'h00;

    always @(posedge clk) begin
        cv_d <= adc_convst_o;
        if (adc_convst_o && !cv_d) rise_age <= 0;
        else if (rise_age < 1000) rise_age <= rise_age + 1;
        if (!adc_convst_o && cv_d && !m_busy && !m_noresp) begin
            if (m_asleep && rise_age < PWRUP - 1) wake_viol <= wake_viol + 1;
            m_busy <= 1'b1;
            m_rem  <= m_len;
        end else if (m_busy) begin
            if (m_rem == 1) begin
                m_busy   <= 1'b0;
                m_asleep <= !adc_convst_o;
            end
            m_rem <= m_rem - 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    logic exp_cv_idle = 1'b0;

    task automatic run_conv(input logic pd, input logic [7:0] smp, input int len, input bit extra);
        int n = 0, fall_idx = 0, nfalls = 0, hi_cnt = 0, lo_cnt = 0, bfall = 0;
        int rd_cnt = 0, rd_first = 0, cs_bad = 0, vcnt = 0, v_idx = 0, vdata = 0, cv_bfall = 0;
        bit lo_done = 0, done = 0;
        logic prev_cv, prev_busy, wake;
        m_sample = smp;
        m_len    = len;
        pdown_i  = pd;
        wake     = pd || !exp_cv_idle;
        prev_cv  = adc_convst_o;
        prev_busy = adc_busy_i;
        start_i  = 1'b1;
        while (!done) begin
            @(negedge clk);
            n++;
            if (n == 1) start_i = 1'b0;
            if (extra && n == 6) begin start_i = 1'b1; pdown_i = !pd; end
            if (extra && n == 7) start_i = 1'b0;
            if (prev_cv && !adc_convst_o) begin
                nfalls++;
                if (fall_idx == 0) fall_idx = n;
            end
            if (adc_convst_o && fall_idx == 0) hi_cnt++;
            if (fall_idx != 0 && !lo_done) begin
                if (!adc_convst_o) lo_cnt++;
                else lo_done = 1;
            end
            if (prev_busy && !adc_busy_i && bfall == 0) begin
                bfall = n;
                cv_bfall = adc_convst_o;
            end
            if (!adc_rd_n_o) begin
                rd_cnt++;
                if (rd_first == 0) rd_first = n;
                if (adc_cs_n_o) cs_bad++;
            end
            if (valid_o) begin
                vcnt++;
                v_idx = n;
                vdata = data_o;
            end
            prev_cv = adc_convst_o;
            prev_busy = adc_busy_i;
            if ((vcnt > 0 && n == v_idx + GAP + 4) || n > 400) done = 1;
        end
        pdown_i = pd;
        if (wake) begin
            chk(pd ? "R2 wake width" : "R4 wake width", hi_cnt, PWRUP);
            chk(pd ? "R2 fall index" : "R4 fall index", fall_idx, PWRUP + 1);
        end else begin
            chk("R3 fall index", fall_idx, 1);
        end
        if (!pd) chk("R3 low pulse width", lo_cnt, PULSE);
        chk(pd ? "R2 convst at busy fall" : "R3 convst at busy fall", cv_bfall, pd ? 0 : 1);
        chk("R5 read start after busy fall", rd_first - bfall, SYNC + 1);
        chk("R5 read width", rd_cnt, RDC);
        chk("R5 cs low with rd", cs_bad, 0);
        chk("R6 valid count", vcnt, 1);
        chk("R6 valid timing", v_idx - bfall, SYNC + 1 + RDC);
        chk("R6 data", vdata, int'(smp));
        chk("R10 data held", int'(data_o), int'(smp));
        if (extra) chk("R8 single fall", nfalls, 1);
        exp_cv_idle = !pd;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 convst in reset", adc_convst_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 convst", adc_convst_o, 0);
        chk("R1 cs_n", adc_cs_n_o, 1);
        chk("R1 rd_n", adc_rd_n_o, 1);
        chk("R1 valid", valid_o, 0);
        chk("R1 err", err_o, 0);
        @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            run_conv(VEC[i][16], VEC[i][15:8], int'(VEC[i][7:0]), 1'b0);
        end

        // R8: requests and mode change during a cycle
        run_conv(1'b1, 8'h77, 18, 1'b1);
        run_conv(1'b0, 8'h19, 18, 1'b1);

        // R9: converter never responds
        begin
            int n = 0, f = 0, e = 0, ecnt = 0, vc = 0, rdc = 0;
            logic prev_cv = adc_convst_o;
            m_noresp = 1'b1;
            pdown_i = 1'b1;
            start_i = 1'b1;
            while (n < TMO + PWRUP + GAP + 10) begin
                @(negedge clk);
                n++;
                if (n == 1) start_i = 1'b0;
                if (prev_cv && !adc_convst_o && f == 0) f = n;
                if (err_o) begin ecnt++; if (e == 0) e = n; end
                if (valid_o) vc++;
                if (!adc_rd_n_o) rdc++;
                prev_cv = adc_convst_o;
            end
            chk("R9 error delay", e - f, TMO);
            chk("R9 error width", ecnt, 1);
            chk("R9 no valid", vc, 0);
            chk("R9 no read", rdc, 0);
            chk("R10 data held after error", int'(data_o), 8'h19);
            m_noresp = 1'b0;
            exp_cv_idle = 1'b0;
        end
        run_conv(1'b1, 8'hC3, 25, 1'b0);

        // R7: start held high from the moment read rises
        begin
            int k = 0, guard = 0;
            m_sample = 8'h66;
            m_len = 14;
            pdown_i = 1'b0;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            while (!valid_o && guard < 400) begin @(negedge clk); guard++; end
            start_i = 1'b1;
            while (adc_convst_o && k < 200) begin @(negedge clk); k++; end
            start_i = 1'b0;
            chk("R7 fall after read rise", k, GAP + 1);
            guard = 0;
            while (!valid_o && guard < 400) begin @(negedge clk); guard++; end
            chk("R6 data after held start", int'(data_o), 8'h66);
            repeat (GAP + 4) @(negedge clk);
        end

        chk("R2 early fall seen by converter", wake_viol, 0);
        summary();
        $finish;
    end
endmodule